// File: doc/BRIEF.md
# Serial Front End for a 14-Bit Voltage DAC

This block is the digital input stage of a single-channel 14-bit voltage-output converter. A host writes to it over a three-wire link that only carries data into the block. The wires are an active-low frame select, a serial clock and a serial data line. Each write is a 16-bit word. Its two top bits choose between normal operation and one of three powered-down states, and its low fourteen bits are the conversion code. The block keeps the code and the mode in a register and drives the converter's output enable and its powered-down load selection from the mode.

All three link wires are asynchronous to the system clock. Each one passes through a two-stage synchronizer, and the block finds serial clock edges and frame select edges by comparing the synchronized level with its value one cycle earlier. A frame starts when frame select falls. Data is taken on each falling serial clock edge. The register loads on the sixteenth falling edge. If frame select rises before that edge, the frame is dropped. After reset the code is all zeros and the mode is normal, so the analog output stays at ground until the first complete write.

Top module: `dac_serial_frontend`

## Requirements
- R1: After reset, `dac_code_o` is 0, `pd_mode_o` is 2'b00, `out_en_o` is 1 and `load_sel_o` is 3'b000.
- R2: Bits are shifted in most significant first. In the 16-bit word, bits 15:14 are the mode and bits 13:0 are the code. Both are loaded on the 16th falling serial clock edge of a frame.
- R3: Before the 16th falling edge of a frame, `dac_code_o` and `pd_mode_o` keep their previous values.
- R4: If frame select rises before the 16th falling edge, the frame is discarded and the outputs do not change. The next frame starts counting from its first bit.
- R5: Falling serial clock edges after the 16th one in the same frame do not change the outputs. They stay ignored until frame select goes high and falls again.
- R6: `out_en_o` is 1 only in mode 2'b00, and `load_sel_o` is then 3'b000. Mode 2'b01 gives `load_sel_o` = 3'b001 (low-resistance load to ground). Mode 2'b10 gives 3'b010 (high-resistance load to ground). Mode 2'b11 gives 3'b100 (output left open).
- R7: New output values appear on the third rising system clock edge after the 16th serial clock fall arrives at the pin, and not on an earlier edge.
- R8: Serial clock edges seen while frame select is high shift no data and advance no bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_n_i | input | 1 | Frame select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous; data taken on falling edges |
| din_i | input | 1 | Serial data, asynchronous |
| dac_code_o | output | 14 | Converter code register |
| pd_mode_o | output | 2 | Mode register: 00 normal, 01/10/11 powered down |
| out_en_o | output | 1 | Output buffer enabled (normal mode) |
| load_sel_o | output | 3 | One-hot powered-down load selection |

## Verification
The only result that is due within a fixed number of cycles is the register update. It lands on the third rising clock edge after the last falling serial clock edge: two synchronizer stages and then the register itself. A directed test drives that fall at a falling system clock edge. It checks the old value after the first and second following rising edges and the new value after the third. Every other check is made at least three cycles after a serial clock fall or a frame select rise has settled. That is either four cycles into the next half period of the serial clock, or twelve cycles after frame select returns high, so synchronizer delay never decides a result.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;

  localparam int MODE_W = 2;
  localparam int LOAD_W = 3;

  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_SHIFT = 2'd1,
    FS_HOLD  = 2'd2
  } frame_state_e;

  typedef enum logic [MODE_W-1:0] {
    PD_NONE      = 2'b00,
    PD_LOAD_LOW  = 2'b01,
    PD_LOAD_HIGH = 2'b10,
    PD_OPEN      = 2'b11
  } pd_mode_e;

  // One-hot load selection for a mode; zero in normal operation.
  function automatic logic [LOAD_W-1:0] load_select(input logic [MODE_W-1:0] mode);
    logic [LOAD_W-1:0] sel;
    case (pd_mode_e'(mode))
      PD_LOAD_LOW:  sel = 3'b001;
      PD_LOAD_HIGH: sel = 3'b010;
      PD_OPEN:      sel = 3'b100;
      default:      sel = 3'b000;
    endcase
    return sel;
  endfunction

  function automatic logic buffer_enabled(input logic [MODE_W-1:0] mode);
    return mode == PD_NONE;
  endfunction

endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int          WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;

endmodule

// File: rtl/dacfe_edge.sv
module dacfe_edge #(
  parameter int               WIDTH   = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);

  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= level_i;
  end

  for (genvar g = 0; g < WIDTH; g++) begin : g_edge
    assign rise_o[g] =  level_i[g] & ~prev_q[g];
    assign fall_o[g] = ~level_i[g] &  prev_q[g];
  end

endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
  import dacfe_pkg::*;
#(
  parameter int FRAME_W = 16,
  localparam int CNT_W  = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_lvl_i,
  input  logic               sync_fall_i,
  input  logic               sclk_fall_i,
  input  logic               din_i,
  output logic [FRAME_W-1:0] frame_word_o,
  output logic               load_pulse_o,
  output frame_state_e       state_o,
  output logic [CNT_W-1:0]   bit_cnt_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

  frame_state_e       state_q, state_d;
  logic [FRAME_W-1:0] shift_q;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               shift_en;

  // Word as it stands once the bit now on the data line is taken.
  assign frame_word_o = {shift_q[FRAME_W-2:0], din_i};
  assign shift_en     = (state_q == FS_SHIFT) && !sync_lvl_i && sclk_fall_i;
  assign load_pulse_o = shift_en && (cnt_q == LAST_BIT);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      FS_IDLE: begin
        if (sync_fall_i) begin
          state_d = FS_SHIFT;
          cnt_d   = '0;
        end
      end
      FS_SHIFT: begin
        if (sync_lvl_i) begin
          state_d = FS_IDLE;
        end else if (shift_en) begin
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_BIT) state_d = FS_HOLD;
        end
      end
      FS_HOLD: begin
        if (sync_lvl_i) state_d = FS_IDLE;
      end
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Shift register only clocks data inside an active frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shift_q <= '0;
    else if (shift_en) shift_q <= frame_word_o;
  end

  assign state_o   = state_q;
  assign bit_cnt_o = cnt_q;

endmodule

// File: rtl/dacfe_outreg.sv
module dacfe_outreg
  import dacfe_pkg::*;
#(
  parameter int CODE_W = 14,
  localparam int FRAME_W = CODE_W + MODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic [CODE_W-1:0]  code_o,
  output logic [MODE_W-1:0]  mode_o,
  output logic               out_en_o,
  output logic [LOAD_W-1:0]  load_sel_o
);

  logic [CODE_W-1:0] code_q;
  logic [MODE_W-1:0] mode_q;
  logic              out_en_q;
  logic [LOAD_W-1:0] load_sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q     <= '0;
      mode_q     <= PD_NONE;
      out_en_q   <= 1'b1;
      load_sel_q <= '0;
    end else if (load_i) begin
      code_q     <= word_i[CODE_W-1:0];
      mode_q     <= word_i[FRAME_W-1 -: MODE_W];
      out_en_q   <= buffer_enabled(word_i[FRAME_W-1 -: MODE_W]);
      load_sel_q <= load_select(word_i[FRAME_W-1 -: MODE_W]);
    end
  end

  assign code_o     = code_q;
  assign mode_o     = mode_q;
  assign out_en_o   = out_en_q;
  assign load_sel_o = load_sel_q;

endmodule

// File: rtl/dac_serial_frontend.sv
module dac_serial_frontend
  import dacfe_pkg::*;
#(
  parameter int CODE_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic [1:0]        pd_mode_o,
  output logic              out_en_o,
  output logic [2:0]        load_sel_o
);

  localparam int FRAME_W = CODE_W + MODE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  // Synchronized pins: {frame select, serial clock, data}.
  logic [2:0] pins_s;
  logic       sync_lvl, sclk_lvl, din_lvl;
  logic [1:0] edge_rise, edge_fall;

  // Named internal events for the checker.
  logic               sync_fall, sclk_fall;
  logic               load_pulse;
  logic [FRAME_W-1:0] frame_word;
  frame_state_e       frame_state;
  logic [CNT_W-1:0]   bit_cnt;

  dacfe_sync #(.WIDTH(3), .RST_VAL(3'b110)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sync_n_i, sclk_i, din_i}),
    .sync_o  (pins_s)
  );

  assign sync_lvl = pins_s[2];
  assign sclk_lvl = pins_s[1];
  assign din_lvl  = pins_s[0];

  dacfe_edge #(.WIDTH(2), .RST_VAL(2'b11)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i ({sync_lvl, sclk_lvl}),
    .rise_o  (edge_rise),
    .fall_o  (edge_fall)
  );

  assign sync_fall = edge_fall[1];
  assign sclk_fall = edge_fall[0];

  dacfe_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync_lvl_i   (sync_lvl),
    .sync_fall_i  (sync_fall),
    .sclk_fall_i  (sclk_fall),
    .din_i        (din_lvl),
    .frame_word_o (frame_word),
    .load_pulse_o (load_pulse),
    .state_o      (frame_state),
    .bit_cnt_o    (bit_cnt)
  );

  dacfe_outreg #(.CODE_W(CODE_W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_pulse),
    .word_i     (frame_word),
    .code_o     (dac_code_o),
    .mode_o     (pd_mode_o),
    .out_en_o   (out_en_o),
    .load_sel_o (load_sel_o)
  );

  logic unused_rise;
  assign unused_rise = ^edge_rise;

endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker
  import dacfe_pkg::*;
#(
  parameter int CODE_W = 14,
  localparam int FRAME_W = CODE_W + MODE_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sync_lvl,
  input logic               load_pulse,
  input logic [FRAME_W-1:0] frame_word,
  input frame_state_e       frame_state,
  input logic [CNT_W-1:0]   bit_cnt,
  input logic [CODE_W-1:0]  dac_code_o,
  input logic [1:0]         pd_mode_o,
  input logic               out_en_o,
  input logic [2:0]         load_sel_o
);

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_pulse |=> (dac_code_o == $past(frame_word[CODE_W-1:0])) &&
                   (pd_mode_o  == $past(frame_word[FRAME_W-1 -: MODE_W])));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_pulse |=> $stable(dac_code_o) && $stable(pd_mode_o) &&
                    $stable(out_en_o) && $stable(load_sel_o));

  assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lvl |-> !load_pulse);

  assert_ignore_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_state == FS_HOLD) |-> !load_pulse);

  assert_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_o |-> (load_sel_o == 3'b000) && (pd_mode_o == 2'b00));

  assert_powered_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_o |-> ($countones(load_sel_o) == 1) && (pd_mode_o != 2'b00));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lvl |=> $stable(bit_cnt));

endmodule

bind dac_serial_frontend dacfe_checker #(.CODE_W(CODE_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_lvl    (sync_lvl),
  .load_pulse  (load_pulse),
  .frame_word  (frame_word),
  .frame_state (frame_state),
  .bit_cnt     (bit_cnt),
  .dac_code_o  (dac_code_o),
  .pd_mode_o   (pd_mode_o),
  .out_en_o    (out_en_o),
  .load_sel_o  (load_sel_o)
);

// File: tb/dac_serial_frontend_tb.sv
`timescale 1ns/1ps
module dac_serial_frontend_tb;

  localparam int HP = 4;  // serial clock half period in system clocks

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_n = 1'b1;
  logic        sclk = 1'b1;
  logic        din = 1'b0;
  logic [13:0] dac_code;
  logic [1:0]  pd_mode;
  logic        out_en;
  logic [2:0]  load_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [13:0] exp_code = '0;
  logic [1:0]  exp_mode = '0;

  always #4 clk = ~clk;

  dac_serial_frontend u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_n_i   (sync_n),
    .sclk_i     (sclk),
    .din_i      (din),
    .dac_code_o (dac_code),
    .pd_mode_o  (pd_mode),
    .out_en_o   (out_en),
    .load_sel_o (load_sel)
  );

  function automatic logic [2:0] want_load(input logic [1:0] m);
    if (m == 2'b00) return 3'b000;
    return 3'b001 << (m - 2'd1);
  endfunction

  task automatic check_outputs(input string req);
    logic [19:0] got, want;
    got  = {dac_code, pd_mode, out_en, load_sel};
    want = {exp_code, exp_mode, (exp_mode == 2'b00), want_load(exp_mode)};
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: code/mode/en/load got %h/%b/%b/%b expected %h/%b/%b/%b",
               req, got[19:6], got[5:4], got[3], got[2:0],
               want[19:6], want[5:4], want[3], want[2:0]);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Send nbits of w (MSB first) then extra clock pulses; mid_check probes R3.
  task automatic send_frame(input logic [15:0] w, input int nbits,
                            input int extra, input bit mid_check);
    sync_n = 1'b0;
    wait_clk(2 * HP);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1; din = w[15 - i];
      wait_clk(HP);
      sclk = 1'b0;
      wait_clk(HP);
      if (mid_check && i == 14) check_outputs("R3 no update before 16th edge");
    end
    for (int j = 0; j < extra; j++) begin
      sclk = 1'b1; din = 1'($urandom);
      wait_clk(HP);
      sclk = 1'b0;
      wait_clk(HP);
    end
    sclk = 1'b1;
    wait_clk(HP);
    sync_n = 1'b1;
    wait_clk(3 * HP);
    if (nbits >= 16) begin
      exp_code = w[13:0];
      exp_mode = w[15:14];
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0D11));
    wait_clk(5);
    check_outputs("R1 reset state");
    rst_n = 1'b1;
    wait_clk(5);
    check_outputs("R1 after reset release");

    // R2: directed words covering each mode and code extremes.
    send_frame(16'h3FFF, 16, 0, 1'b1); check_outputs("R2 full-scale normal");
    send_frame(16'h5555, 16, 0, 1'b0); check_outputs("R2/R6 mode 01");
    send_frame(16'hAAAA, 16, 0, 1'b0); check_outputs("R2/R6 mode 10");
    send_frame(16'hC001, 16, 0, 1'b1); check_outputs("R2/R6 mode 11");
    send_frame(16'h0000, 16, 0, 1'b0); check_outputs("R2 zero code");

    // R4: abort after 10 bits, then a fresh full frame.
    send_frame(16'hFFFF, 10, 0, 1'b0); check_outputs("R4 aborted frame");
    send_frame(16'h1234, 16, 0, 1'b0); check_outputs("R4 frame after abort");
    send_frame(16'hBEEF, 15, 0, 1'b0); check_outputs("R4 abort at 15 bits");

    // R5: extra edges after the 16th.
    send_frame(16'h6A5C, 16, 5, 1'b0); check_outputs("R5 extra edges ignored");

    // R8: serial clock activity with frame select high.
    for (int k = 0; k < 12; k++) begin
      sclk = 1'b0; din = 1'($urandom); wait_clk(HP);
      sclk = 1'b1; wait_clk(HP);
    end
    check_outputs("R8 idle clocks no effect");
    send_frame(16'h2C3A, 16, 0, 1'b0); check_outputs("R8 frame after idle clocks");

    // R7: latency of the final edge, driven at a falling system clock edge.
    begin
      logic [15:0] w = 16'h9F0E;
      sync_n = 1'b0;
      wait_clk(2 * HP);
      for (int i = 0; i < 16; i++) begin
        sclk = 1'b1; din = w[15 - i];
        wait_clk(HP);
        sclk = 1'b0;
        if (i < 15) wait_clk(HP);
      end
      wait_clk(2);
      check_outputs("R7 old value two edges after last fall");
      wait_clk(1);
      exp_code = w[13:0];
      exp_mode = w[15:14];
      check_outputs("R7 new value on third edge");
      wait_clk(HP);
      sclk = 1'b1; wait_clk(HP);
      sync_n = 1'b1; wait_clk(3 * HP);
    end

    // Random frames: mostly complete, some aborted, some with extra edges.
    for (int n = 0; n < 60; n++) begin
      logic [15:0] w;
      int sel, nb, ex;
      w   = 16'($urandom);
      sel = int'($urandom_range(0, 9));
      nb  = (sel < 2) ? int'($urandom_range(1, 15)) : 16;
      ex  = (sel == 9) ? int'($urandom_range(1, 4)) : 0;
      send_frame(w, nb, ex, 1'b0);
      check_outputs(nb < 16 ? "R4 random abort" : (ex > 0 ? "R5 random extra" : "R2 random frame"));
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule